// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Parity Error Signalling

This block is a single-wire asynchronous transceiver for a smart-card style link. Transmit and receive share one open-drain line. The block pulls the line low only through `line_pull_low`, and it reads the line state back on `line_in`. A free-running baud generator divides the system clock by a selectable prescaler of 1, 8 or 32. It then divides by a programmable value n+1 to form an oversampling tick. One bit lasts 16 ticks. Each frame carries a low start bit, eight data bits sent least significant bit first, an even parity bit and one stop bit.

When the receiver finds a parity mismatch, it drives the line low during the stop-bit slot in place of the idle-high stop level. This tells the far end that the character was corrupted. The transmitter samples the middle of its own stop-bit slot. If it reads low there, it records that the peer flagged an error. Firmware handles retransmission; that is outside this block.

Status flags and two interrupt requests are brought out as plain signals. A one-cycle strobe clears each of them.

Top module: `sc_uart`

## Requirements
- R1: The bit time equals 16*(baud_div+1)*P clock cycles. P is 1 when clk_sel is 0, 8 when it is 1, and 32 when it is 2 or 3.
- R2: A transmitted frame consists of a low start bit, data bits 0 to 7 in ascending order, a parity bit equal to the XOR of the data bits (even parity), and a high stop bit. A 0 bit is sent by asserting line_pull_low; a 1 bit is sent by releasing it.
- R3: After reset, tx_buf_empty and tx_reg_empty are 1. A tx_wr pulse clears tx_buf_empty in the next cycle. The byte then moves to the shift register on the next oversampling tick: tx_buf_empty returns to 1, tx_reg_empty drops to 0 and the start bit begins, all in the same cycle. tx_reg_empty returns to 1 when the stop bit ends.
- R4: With tx_irq_sel = 0, tx_irq sets when the byte moves from the buffer to the shift register. With tx_irq_sel = 1, tx_irq sets when the stop bit ends.
- R5: While tx_en is 0, no frame starts and a written byte stays in the buffer. While rx_en is 0, frames on the line are not captured and rx_full stays as it was.
- R6: When a received frame completes, rx_rdata holds its data bits and rx_full and rx_irq set. This applies to the block's own transmitted frames as well. An rx_rd pulse clears rx_full.
- R7: On a received parity mismatch, the block asserts line_pull_low for one bit time, starting at the stop-bit boundary. It also sets the sticky par_err flag, which stays set until a par_err_clr pulse. A frame with correct parity gives no low pulse and leaves par_err unchanged.
- R8: If the line reads low at the middle of the transmitted stop bit, the sticky peer_err flag sets. It stays set until a peer_err_clr pulse.
- R9: The receiver accepts a start bit only if the line is still low at mid-bit. A low glitch shorter than half a bit is ignored, and a later valid frame is received correctly.
- R10: A tx_irq_clr or rx_irq_clr pulse clears the matching request in the next cycle, unless a new set event occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 8 | Baud divider value n |
| clk_sel | input | 2 | Prescaler select: 0 gives /1, 1 gives /8, 2 or 3 gives /32 |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_irq_sel | input | 1 | Transmit request source: 0 for buffer empty, 1 for frame complete |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive buffer; clears rx_full |
| rx_rdata | output | 8 | Last received byte |
| tx_buf_empty | output | 1 | Transmit buffer holds no byte |
| tx_reg_empty | output | 1 | No frame is shifting |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| par_err | output | 1 | Sticky received parity error |
| par_err_clr | input | 1 | Clears par_err |
| peer_err | output | 1 | Sticky flag: the peer signalled an error on a transmitted frame |
| peer_err_clr | input | 1 | Clears peer_err |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_irq_clr | input | 1 | Clears tx_irq |
| rx_irq | output | 1 | Receive interrupt request |
| rx_irq_clr | input | 1 | Clears rx_irq |
| line_in | input | 1 | Level of the shared line |
| line_pull_low | output | 1 | Open-drain pull-down of the shared line |

## Verification
The bench sends bytes whose bit 0 is 1 under three prescaler and divider settings and measures the start-bit width. This separates the /1, /8 and /32 paths and the n+1 factor. A modelled peer sends frames with correct and with corrupted parity. This separates the normal stop level from the error pulse and the sticky flag, and the bench also checks loopback reception of the block's own frames. The peer pulls the stop slot low on one transmitted frame, which shows that the transmit-side sample is taken. A short low glitch, a disabled transmitter and a disabled receiver show that spurious starts and gated directions leave the outputs untouched.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  localparam int unsigned SC_DATA_W = 8;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_HALF  = 3'd3,
    RX_FLAG  = 3'd4
  } rx_state_t;

  // even parity bit: makes the count of ones across data and parity even
  function automatic logic even_par(input logic [SC_DATA_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/sc_baud_gen.sv
module sc_baud_gen #(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned PRE_MID  = 8,
  parameter int unsigned PRE_SLOW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic [1:0]       src_sel,
  output logic             os_tick
);
  localparam int unsigned PRE_W = $clog2(PRE_SLOW);

  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic [DIV_W-1:0] bc_q, bc_d;
  logic             pre_tick;
  logic             bc_wrap;

  always_comb begin
    case (src_sel)
      2'd0:    pre_lim = '0;
      2'd1:    pre_lim = PRE_W'(PRE_MID - 1);
      default: pre_lim = PRE_W'(PRE_SLOW - 1);
    endcase
    pre_tick = (pre_q >= pre_lim);
    pre_d    = pre_tick ? '0 : pre_q + 1'b1;
    bc_wrap  = (bc_q >= div_val);
    bc_d     = bc_q;
    if (pre_tick) begin
      bc_d = bc_wrap ? '0 : bc_q + 1'b1;
    end
    os_tick = pre_tick && bc_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      bc_q  <= '0;
    end else begin
      pre_q <= pre_d;
      bc_q  <= bc_d;
    end
  end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_uart_pkg::*;
#(
  parameter int unsigned DATA_W = SC_DATA_W,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              en,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              line_s,
  output logic              load,
  output logic              done,
  output logic              busy,
  output logic              drive_low,
  output logic              stop_low
);
  localparam int unsigned FRAME_BITS = DATA_W + 3;
  localparam int unsigned SUB_W      = $clog2(OVS);
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned SUB_MID    = OVS / 2;

  tx_state_t             st_q, st_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [SUB_W-1:0]      sub_q, sub_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  adv, last_sub, at_stop;

  always_comb begin
    load      = (st_q == TX_IDLE) && en && buf_full && os_tick;
    adv       = (st_q == TX_SHIFT) && en && os_tick;
    last_sub  = (sub_q == SUB_W'(OVS - 1));
    at_stop   = (idx_q == IDX_W'(FRAME_BITS - 1));
    done      = adv && last_sub && at_stop;
    stop_low  = adv && at_stop && (sub_q == SUB_W'(SUB_MID)) && !line_s;
    busy      = (st_q == TX_SHIFT);
    drive_low = (st_q == TX_SHIFT) && !sh_q[0];

    st_d  = st_q;
    sh_d  = sh_q;
    sub_d = sub_q;
    idx_d = idx_q;
    if (load) begin
      st_d  = TX_SHIFT;
      sh_d  = {1'b1, even_par(buf_data), buf_data, 1'b0};
      sub_d = '0;
      idx_d = '0;
    end else if (adv) begin
      if (last_sub) begin
        sub_d = '0;
        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
        idx_d = idx_q + 1'b1;
        if (at_stop) begin
          st_d = TX_IDLE;
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      sh_q  <= '1;
      sub_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      sub_q <= sub_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_uart_pkg::*;
#(
  parameter int unsigned DATA_W = SC_DATA_W,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              en,
  input  logic              line_s,
  output logic              cap,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_perr,
  output logic              drive_low
);
  localparam int unsigned DBITS   = DATA_W + 1;
  localparam int unsigned SUB_W   = $clog2(OVS);
  localparam int unsigned CNT_W   = $clog2(DBITS + 1);
  localparam int unsigned SUB_MID = OVS / 2;

  rx_state_t         st_q, st_d;
  logic [DBITS-1:0]  sh_q, sh_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              tick;

  always_comb begin
    tick      = os_tick && en;
    cap_data  = sh_q[DATA_W-1:0];
    cap_perr  = ^sh_q;
    drive_low = (st_q == RX_FLAG);
    cap       = 1'b0;

    st_d  = st_q;
    sh_d  = sh_q;
    sub_d = sub_q;
    cnt_d = cnt_q;
    if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!line_s) begin
            st_d  = RX_START;
            sub_d = '0;
          end
        end
        RX_START: begin
          if (sub_q == SUB_W'(SUB_MID - 1)) begin
            sub_d = '0;
            cnt_d = '0;
            st_d  = line_s ? RX_IDLE : RX_DATA;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (sub_q == SUB_W'(OVS - 1)) begin
            sub_d = '0;
            sh_d  = {line_s, sh_q[DBITS-1:1]};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DBITS - 1)) begin
              st_d = RX_HALF;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        RX_HALF: begin
          if (sub_q == SUB_W'(SUB_MID - 1)) begin
            cap   = 1'b1;
            sub_d = '0;
            st_d  = cap_perr ? RX_FLAG : RX_IDLE;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        RX_FLAG: begin
          if (sub_q == SUB_W'(OVS - 1)) begin
            sub_d = '0;
            st_d  = RX_IDLE;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      sh_q  <= '0;
      sub_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      sub_q <= sub_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sc_uart.sv
module sc_uart
  import sc_uart_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = SC_DATA_W,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [1:0]        clk_sel,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_irq_sel,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              tx_buf_empty,
  output logic              tx_reg_empty,
  output logic              rx_full,
  output logic              par_err,
  input  logic              par_err_clr,
  output logic              peer_err,
  input  logic              peer_err_clr,
  output logic              tx_irq,
  input  logic              tx_irq_clr,
  output logic              rx_irq,
  input  logic              rx_irq_clr,
  input  logic              line_in,
  output logic              line_pull_low
);
  logic [1:0]        rst_sync;
  logic              rst_s;
  logic [1:0]        line_sync;
  logic              line_s;
  logic              os_tick;
  logic              tx_load, tx_done, tx_busy, tx_drive_low, tx_stop_low;
  logic              rx_cap, rx_cap_perr, rx_drive_low;
  logic [DATA_W-1:0] rx_cap_data;

  logic              buf_full_q, buf_full_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic [DATA_W-1:0] rbuf_q, rbuf_d;
  logic              rx_full_q, rx_full_d;
  logic              perr_q, perr_d;
  logic              peer_q, peer_d;
  logic              txi_q, txi_d, tx_irq_set;
  logic              rxi_q, rxi_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  // the shared line is asynchronous to clk
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) line_sync <= 2'b11;
    else        line_sync <= {line_sync[0], line_in};
  end
  assign line_s = line_sync[1];

  sc_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_s),
    .div_val (baud_div),
    .src_sel (clk_sel),
    .os_tick (os_tick)
  );

  sc_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_s),
    .os_tick   (os_tick),
    .en        (tx_en),
    .buf_full  (buf_full_q),
    .buf_data  (buf_q),
    .line_s    (line_s),
    .load      (tx_load),
    .done      (tx_done),
    .busy      (tx_busy),
    .drive_low (tx_drive_low),
    .stop_low  (tx_stop_low)
  );

  sc_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_s),
    .os_tick   (os_tick),
    .en        (rx_en),
    .line_s    (line_s),
    .cap       (rx_cap),
    .cap_data  (rx_cap_data),
    .cap_perr  (rx_cap_perr),
    .drive_low (rx_drive_low)
  );

  always_comb begin
    buf_full_d = tx_load ? 1'b0 : buf_full_q;
    buf_d      = buf_q;
    if (tx_wr) begin
      buf_full_d = 1'b1;
      buf_d      = tx_wdata;
    end
    rbuf_d     = rx_cap ? rx_cap_data : rbuf_q;
    rx_full_d  = rx_cap | (rx_full_q & ~rx_rd);
    perr_d     = (rx_cap & rx_cap_perr) | (perr_q & ~par_err_clr);
    peer_d     = tx_stop_low | (peer_q & ~peer_err_clr);
    tx_irq_set = tx_irq_sel ? tx_done : tx_load;
    txi_d      = tx_irq_set | (txi_q & ~tx_irq_clr);
    rxi_d      = rx_cap | (rxi_q & ~rx_irq_clr);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      buf_full_q <= 1'b0;
      buf_q      <= '0;
      rbuf_q     <= '0;
      rx_full_q  <= 1'b0;
      perr_q     <= 1'b0;
      peer_q     <= 1'b0;
      txi_q      <= 1'b0;
      rxi_q      <= 1'b0;
    end else begin
      buf_full_q <= buf_full_d;
      buf_q      <= buf_d;
      rbuf_q     <= rbuf_d;
      rx_full_q  <= rx_full_d;
      perr_q     <= perr_d;
      peer_q     <= peer_d;
      txi_q      <= txi_d;
      rxi_q      <= rxi_d;
    end
  end

  assign rx_rdata      = rbuf_q;
  assign tx_buf_empty  = ~buf_full_q;
  assign tx_reg_empty  = ~tx_busy;
  assign rx_full       = rx_full_q;
  assign par_err       = perr_q;
  assign peer_err      = peer_q;
  assign tx_irq        = txi_q;
  assign rx_irq        = rxi_q;
  assign line_pull_low = tx_drive_low | rx_drive_low;
endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rx_en,
  input logic tx_wr,
  input logic tx_irq_sel,
  input logic tx_load,
  input logic tx_irq_set,
  input logic rx_cap,
  input logic rx_rd,
  input logic tx_buf_empty,
  input logic tx_reg_empty,
  input logic rx_full,
  input logic par_err,
  input logic par_err_clr,
  input logic peer_err,
  input logic peer_err_clr,
  input logic tx_irq,
  input logic tx_irq_clr,
  input logic rx_irq,
  input logic rx_irq_clr
);
  a_r3_load_moves_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !tx_wr |=> tx_buf_empty && !tx_reg_empty);

  a_r5_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reg_empty && !tx_en |=> tx_reg_empty);

  a_r5_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !rx_full |=> !rx_full);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !rx_cap |=> !rx_full);

  a_r7_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    par_err && !par_err_clr |=> par_err);

  a_r8_peer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    peer_err && !peer_err_clr |=> peer_err);

  a_r4_complete_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) && $past(tx_irq_sel) |-> $rose(tx_reg_empty));

  a_r10_tx_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_clr && !tx_irq_set |=> !tx_irq);

  a_r10_rx_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_clr && !rx_cap |=> !rx_irq);
endmodule

bind sc_uart sc_uart_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_s),
  .tx_en        (tx_en),
  .rx_en        (rx_en),
  .tx_wr        (tx_wr),
  .tx_irq_sel   (tx_irq_sel),
  .tx_load      (tx_load),
  .tx_irq_set   (tx_irq_set),
  .rx_cap       (rx_cap),
  .rx_rd        (rx_rd),
  .tx_buf_empty (tx_buf_empty),
  .tx_reg_empty (tx_reg_empty),
  .rx_full      (rx_full),
  .par_err      (par_err),
  .par_err_clr  (par_err_clr),
  .peer_err     (peer_err),
  .peer_err_clr (peer_err_clr),
  .tx_irq       (tx_irq),
  .tx_irq_clr   (tx_irq_clr),
  .rx_irq       (rx_irq),
  .rx_irq_clr   (rx_irq_clr)
);

// File: tb/sc_uart_bench.sv
module sc_uart_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] baud_div;
  logic [1:0] clk_sel;
  logic       tx_en, rx_en, tx_irq_sel, tx_wr, rx_rd;
  logic [7:0] tx_wdata;
  logic [7:0] rx_rdata;
  logic       tx_buf_empty, tx_reg_empty, rx_full, par_err, peer_err;
  logic       par_err_clr, peer_err_clr, tx_irq, tx_irq_clr, rx_irq, rx_irq_clr;
  logic       line_pull_low;
  logic       peer_low;
  wire        line = !(line_pull_low || peer_low);

  int checks = 0;
  int errors = 0;
  int bit_clks = 16;
  bit finished = 0;

  sc_uart u_sc_uart (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .clk_sel(clk_sel),
    .tx_en(tx_en), .rx_en(rx_en), .tx_irq_sel(tx_irq_sel),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .tx_buf_empty(tx_buf_empty), .tx_reg_empty(tx_reg_empty), .rx_full(rx_full),
    .par_err(par_err), .par_err_clr(par_err_clr),
    .peer_err(peer_err), .peer_err_clr(peer_err_clr),
    .tx_irq(tx_irq), .tx_irq_clr(tx_irq_clr),
    .rx_irq(rx_irq), .rx_irq_clr(rx_irq_clr),
    .line_in(line), .line_pull_low(line_pull_low)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_to(input int target, inout int pos);
    while (pos < target) begin
      @(negedge clk);
      pos++;
    end
  endtask

  task automatic configure(input logic [7:0] n, input logic [1:0] sel);
    int p;
    @(negedge clk);
    baud_div = n;
    clk_sel  = sel;
    p = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 8 : 32;
    bit_clks = 16 * (int'(n) + 1) * p;
  endtask

  // which: 0 rx_rd, 1 tx_irq_clr, 2 rx_irq_clr, 3 par_err_clr, 4 peer_err_clr
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: rx_rd = 1'b1;
      1: tx_irq_clr = 1'b1;
      2: rx_irq_clr = 1'b1;
      3: par_err_clr = 1'b1;
      default: peer_err_clr = 1'b1;
    endcase
    @(negedge clk);
    rx_rd = 1'b0; tx_irq_clr = 1'b0; rx_irq_clr = 1'b0;
    par_err_clr = 1'b0; peer_err_clr = 1'b0;
  endtask

  // writes a byte, then decodes the frame the block sends on the line
  task automatic dev_send(input logic [7:0] d, input bit flag, input bit measure,
                          output logic [7:0] got, output logic par, output logic stp,
                          output int width, output logic be_wr, output logic be_ld,
                          output logic re_ld, output logic irq_ld);
    int pos;
    int guard;
    @(negedge clk);
    tx_wr = 1'b1;
    tx_wdata = d;
    @(negedge clk);
    tx_wr = 1'b0;
    be_wr = tx_buf_empty;
    guard = 0;
    while (line && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    be_ld = tx_buf_empty;
    re_ld = tx_reg_empty;
    irq_ld = tx_irq;
    pos = 0;
    width = 0;
    if (measure) begin
      while (!line && width < 20000) begin
        width++;
        @(negedge clk);
        pos++;
      end
    end
    for (int k = 0; k < 8; k++) begin
      wait_to((k + 1) * bit_clks + bit_clks / 2, pos);
      got[k] = line;
    end
    wait_to(9 * bit_clks + bit_clks / 2, pos);
    par = line;
    if (flag) begin
      wait_to(10 * bit_clks, pos);
      peer_low = 1'b1;
    end
    wait_to(10 * bit_clks + bit_clks / 2, pos);
    stp = line;
    wait_to(11 * bit_clks, pos);
    peer_low = 1'b0;
    wait_to(11 * bit_clks + 4, pos);
  endtask

  // the modelled peer sends one frame; reports whether the stop slot read low
  task automatic peer_send(input logic [7:0] d, input bit badpar, output logic saw_low);
    logic p;
    p = (^d) ^ badpar;
    @(negedge clk);
    peer_low = 1'b1;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      peer_low = ~d[i];
      repeat (bit_clks) @(negedge clk);
    end
    peer_low = ~p;
    repeat (bit_clks) @(negedge clk);
    peer_low = 1'b0;
    repeat (bit_clks / 2) @(negedge clk);
    saw_low = !line;
    repeat (bit_clks / 2 + bit_clks + 4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic par, stp, be_wr, be_ld, re_ld, irq_ld, saw;
    int width;
    int lows;

    rst_n = 1'b0; baud_div = 8'd0; clk_sel = 2'd0;
    tx_en = 1'b0; rx_en = 1'b0; tx_irq_sel = 1'b0; tx_wr = 1'b0; tx_wdata = 8'h00;
    rx_rd = 1'b0; par_err_clr = 1'b0; peer_err_clr = 1'b0;
    tx_irq_clr = 1'b0; rx_irq_clr = 1'b0; peer_low = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R3 reset tx_buf_empty", int'(tx_buf_empty), 1);
    chk("R3 reset tx_reg_empty", int'(tx_reg_empty), 1);
    chk("R6 reset rx_full", int'(rx_full), 0);
    chk("R10 reset irqs", int'({tx_irq, rx_irq}), 0);
    chk("R7 reset line_pull_low", int'(line_pull_low), 0);
    chk("R7 reset par_err", int'(par_err), 0);
    chk("R8 reset peer_err", int'(peer_err), 0);

    // fast config, loopback receive of own frame
    configure(8'd0, 2'd0);
    tx_en = 1'b1; rx_en = 1'b1; tx_irq_sel = 1'b0;
    dev_send(8'hA5, 1'b0, 1'b1, got, par, stp, width, be_wr, be_ld, re_ld, irq_ld);
    chk("R1 start width n=0 /1", width, 16);
    chk("R2 data bits 0xA5", int'(got), 8'hA5);
    chk("R2 parity bit", int'(par), int'(^8'hA5));
    chk("R2 stop high", int'(stp), 1);
    chk("R3 buf not empty after write", int'(be_wr), 0);
    chk("R3 buf empty at load", int'(be_ld), 1);
    chk("R3 reg busy at load", int'(re_ld), 0);
    chk("R4 buffer-empty source irq at load", int'(irq_ld), 1);
    chk("R3 reg empty after stop", int'(tx_reg_empty), 1);
    chk("R8 no peer error", int'(peer_err), 0);
    chk("R6 echo rx_full", int'(rx_full), 1);
    chk("R6 echo data", int'(rx_rdata), 8'hA5);
    chk("R6 echo rx_irq", int'(rx_irq), 1);
    chk("R7 echo no par_err", int'(par_err), 0);
    strobe(1);
    chk("R10 tx_irq cleared", int'(tx_irq), 0);
    strobe(2);
    chk("R10 rx_irq cleared", int'(rx_irq), 0);
    strobe(0);
    chk("R6 rx_rd clears rx_full", int'(rx_full), 0);

    // divider /8 with n=1, completion source for tx irq
    configure(8'd1, 2'd1);
    rx_en = 1'b0; tx_irq_sel = 1'b1;
    dev_send(8'h3B, 1'b0, 1'b1, got, par, stp, width, be_wr, be_ld, re_ld, irq_ld);
    chk("R1 start width n=1 /8", width, 256);
    chk("R2 data bits 0x3B", int'(got), 8'h3B);
    chk("R2 parity 0x3B", int'(par), int'(^8'h3B));
    chk("R4 complete source no irq at load", int'(irq_ld), 0);
    chk("R4 complete source irq after stop", int'(tx_irq), 1);
    chk("R5 rx disabled ignores echo", int'(rx_full), 0);
    strobe(1);

    // divider /32 with n=0, select value 2
    configure(8'd0, 2'd2);
    dev_send(8'h01, 1'b0, 1'b1, got, par, stp, width, be_wr, be_ld, re_ld, irq_ld);
    chk("R1 start width n=0 /32", width, 512);
    chk("R2 data bits 0x01", int'(got), 8'h01);
    strobe(1);

    // receive from peer: good then corrupted parity
    configure(8'd0, 2'd0);
    tx_irq_sel = 1'b0; rx_en = 1'b1;
    peer_send(8'h5C, 1'b0, saw);
    chk("R7 no error pulse on good parity", int'(saw), 0);
    chk("R6 peer rx_full", int'(rx_full), 1);
    chk("R6 peer data 0x5C", int'(rx_rdata), 8'h5C);
    chk("R7 good parity leaves par_err", int'(par_err), 0);
    strobe(0);
    peer_send(8'h96, 1'b1, saw);
    chk("R7 error pulse in stop slot", int'(saw), 1);
    chk("R7 par_err set", int'(par_err), 1);
    chk("R6 bad frame still captured", int'(rx_rdata), 8'h96);
    chk("R7 line released after pulse", int'(line_pull_low), 0);
    repeat (40) @(negedge clk);
    chk("R7 par_err sticky", int'(par_err), 1);
    strobe(3);
    chk("R7 par_err cleared", int'(par_err), 0);
    strobe(0);
    strobe(2);

    // peer flags the block's own transmission
    rx_en = 1'b0;
    dev_send(8'h7E, 1'b1, 1'b0, got, par, stp, width, be_wr, be_ld, re_ld, irq_ld);
    chk("R2 data bits 0x7E", int'(got), 8'h7E);
    chk("R8 peer_err set", int'(peer_err), 1);
    repeat (40) @(negedge clk);
    chk("R8 peer_err sticky", int'(peer_err), 1);
    strobe(4);
    chk("R8 peer_err cleared", int'(peer_err), 0);
    chk("R5 rx disabled no capture", int'(rx_full), 0);

    // transmitter disabled holds the byte
    @(negedge clk);
    tx_en = 1'b0; tx_wr = 1'b1; tx_wdata = 8'h55;
    @(negedge clk);
    tx_wr = 1'b0;
    lows = 0;
    for (int i = 0; i < 3 * bit_clks; i++) begin
      @(negedge clk);
      if (!line) lows++;
    end
    chk("R5 tx disabled line idle", lows, 0);
    chk("R5 tx disabled reg empty", int'(tx_reg_empty), 1);
    chk("R5 tx disabled byte kept", int'(tx_buf_empty), 0);
    tx_en = 1'b1;
    repeat (12 * bit_clks) @(negedge clk);
    chk("R5 tx enabled byte sent", int'(tx_buf_empty), 1);
    chk("R3 frame finished", int'(tx_reg_empty), 1);

    // receiver disabled ignores a peer frame
    peer_send(8'h33, 1'b0, saw);
    chk("R5 rx disabled peer frame ignored", int'(rx_full), 0);

    // short glitch is rejected, next frame received
    rx_en = 1'b1;
    @(negedge clk);
    peer_low = 1'b1;
    repeat (4) @(negedge clk);
    peer_low = 1'b0;
    lows = 0;
    for (int i = 0; i < 20 * bit_clks; i++) begin
      @(negedge clk);
      if (line_pull_low) lows++;
    end
    chk("R9 glitch no capture", int'(rx_full), 0);
    chk("R9 glitch no drive", lows, 0);
    peer_send(8'hC3, 1'b0, saw);
    chk("R9 frame after glitch rx_full", int'(rx_full), 1);
    chk("R9 frame after glitch data", int'(rx_rdata), 8'hC3);
    chk("R9 frame after glitch no par_err", int'(par_err), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule